// File: doc/BRIEF.md
# Polyphase Horizontal Line Scaler

This block resizes one line of 8-bit samples at a time. It captures a source line from a valid/ready pixel stream into a local line store. It then produces the programmed number of output pixels. For each output pixel it evaluates an 8-tap FIR over neighbouring source samples, using one of 32 coefficient phases. A 16.16 fixed-point position accumulator chooses the centre source sample and the phase. The accumulator starts each line at a programmable fractional offset and advances by a step the user programs as `(source_width << 16) / dest_width`.

A chroma plane that is subsampled by a factor F uses the luma width divided by F, rounded up, as its source width. This width is computed outside the block and programmed like any other width.

Coefficients are written through a small word-addressed write port into a shadow table. A commit pulse moves the whole shadow table into the working table. The move happens only between lines, so a line already being produced always uses one consistent set of coefficients.

Top module: `hscale_top`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1. The working table is the pass-through table: in every phase, tap 3 is 64 and every other tap is 0.
- R2: While capturing, the block accepts pixels with `inReady` high. `inSol` puts the pixel at index 0. The line ends at the pixel marked `inEol`, or at pixel `inWidth-1` if that comes first. `inReady` then stays low until the last output of that line has been loaded.
- R3: Each line yields exactly `outWidth` output pixels. `outSol` is set on the first of them and `outEol` on the last. No output appears between lines.
- R4: The position accumulator starts each line at `{16'd0, phaseInit}` and grows by `stepIn` after each output. Bits 31:16 give the centre source index, and bits 15:11 give the phase.
- R5: Word 2p+0 of the table holds taps 0..3 of phase p, and word 2p+1 holds taps 4..7. Tap k sits in bits 8k+7:8k of its word, counting k within the word, and is a signed 8-bit value. Tap t weights the source pixel at centre+t-3.
- R6: A source index below 0 reads pixel 0. A source index above the last captured pixel reads the last captured pixel.
- R7: The tap sum has 32 added, is shifted right arithmetically by 6, and is clamped to the range 0..255.
- R8: Writes to the coefficient port have no visible effect until `cfgCommit` is pulsed. A commit takes effect before the first output of the next line.
- R9: While `outValid` is high and `outReady` is low, `outPix`, `outSol` and `outEol` hold their values. No output pixel is lost or repeated.
- R10: Idle cycles on the input stream (`inValid` low) do not change the captured line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Block can accept an input pixel |
| inPix | input | 8 | Input pixel |
| inSol | input | 1 | First pixel of a line |
| inEol | input | 1 | Last pixel of a line |
| inWidth | input | 7 | Source width, 1..64 |
| outWidth | input | 12 | Destination width, at least 1 |
| stepIn | input | 32 | 16.16 step per output pixel |
| phaseInit | input | 16 | Starting fractional position for each line |
| cfgWrEn | input | 1 | Coefficient word write strobe |
| cfgAddr | input | 6 | Coefficient word index, 2*phase+half |
| cfgWrData | input | 32 | Coefficient word, four signed taps |
| cfgCommit | input | 1 | Move the shadow table into the working table |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Sink accepts the output pixel |
| outPix | output | 8 | Output pixel |
| outSol | output | 1 | First output of a line |
| outEol | output | 1 | Last output of a line |

## Verification
The hardest case to reach from the ports is a coefficient set that has been written but not yet committed, followed by a full line. The stimulus writes a complete new table and then runs a line with no commit, expecting the previous filter. It then commits and runs again, expecting the new filter. Clamping at both ends is driven by a table with a negative tap applied to lines of hard 0/255 steps. The edge-replication rules are driven by a one-pixel line and by upscaling where the window runs past the last pixel. Irregular `outReady` and `inValid` patterns are used across the vector rows to exercise stalls.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef struct packed {
    logic pixWr;
    logic emit;
    logic tblSwap;
    logic firstOut;
    logic lastOut;
  } hsStrobe_t;
endpackage

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
#(
  parameter int LINE_MAX = 64,
  parameter int OCNT_W   = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inSol,
  input  logic inEol,
  output logic inReady,
  input  logic [$clog2(LINE_MAX+1)-1:0] inWidth,
  input  logic [OCNT_W-1:0] outWidth,
  input  logic [31:0] stepIn,
  input  logic [15:0] phaseInit,
  input  logic cfgCommit,
  input  logic outBusy,
  output hsStrobe_t strb,
  output logic [$clog2(LINE_MAX)-1:0] wrAddr,
  output logic [31:0] acc,
  output logic [$clog2(LINE_MAX+1)-1:0] lineLen
);
  localparam int CNT_W  = $clog2(LINE_MAX+1);
  localparam int ADDR_W = $clog2(LINE_MAX);

  typedef enum logic {ST_LOAD, ST_RUN} state_t;
  state_t state;

  logic [ADDR_W-1:0] wrIdx;
  logic [OCNT_W-1:0] outCnt, outLenQ;
  logic [31:0] stepQ;
  logic pending;
  logic inFire, lastIn;

  assign inReady = (state == ST_LOAD);
  assign inFire  = inValid && inReady;
  assign wrAddr  = inSol ? '0 : wrIdx;
  assign lastIn  = inFire && (inEol || (CNT_W'(wrAddr) == inWidth - CNT_W'(1)));

  always_comb begin
    strb          = '0;
    strb.pixWr    = inFire;
    strb.emit     = (state == ST_RUN) && !outBusy;
    strb.tblSwap  = pending && (state == ST_LOAD);
    strb.firstOut = (outCnt == '0);
    strb.lastOut  = strb.emit && (outCnt == outLenQ - OCNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_LOAD;
      wrIdx   <= '0;
      acc     <= '0;
      outCnt  <= '0;
      outLenQ <= OCNT_W'(1);
      lineLen <= CNT_W'(1);
      stepQ   <= '0;
      pending <= 1'b0;
    end else begin
      if (cfgCommit)         pending <= 1'b1;
      else if (strb.tblSwap) pending <= 1'b0;
      case (state)
        ST_LOAD: if (inFire) begin
          if (lastIn) begin
            state   <= ST_RUN;
            lineLen <= CNT_W'(wrAddr) + CNT_W'(1);
            outLenQ <= outWidth;
            stepQ   <= stepIn;
            acc     <= {16'd0, phaseInit};
            outCnt  <= '0;
            wrIdx   <= '0;
          end else begin
            wrIdx <= wrAddr + ADDR_W'(1);
          end
        end
        ST_RUN: if (strb.emit) begin
          acc    <= acc + stepQ;
          outCnt <= outCnt + OCNT_W'(1);
          if (strb.lastOut) state <= ST_LOAD;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (outCnt < outLenQ));
  // R2
  line_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.lastOut |=> inReady);
  // R8
  swap_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && inReady && !cfgCommit) |=> !pending);
endmodule

// File: rtl/hs_datapath.sv
module hs_datapath
  import hs_pkg::*;
#(
  parameter int LINE_MAX = 64,
  parameter int PHASES   = 32
) (
  input  logic clk,
  input  logic rstN,
  input  hsStrobe_t strb,
  input  logic [$clog2(LINE_MAX)-1:0] wrAddr,
  input  logic [7:0] inPix,
  input  logic [31:0] acc,
  input  logic [$clog2(LINE_MAX+1)-1:0] lineLen,
  input  logic cfgWrEn,
  input  logic [$clog2(2*PHASES)-1:0] cfgAddr,
  input  logic [31:0] cfgWrData,
  input  logic outReady,
  output logic outValid,
  output logic [7:0] outPix,
  output logic outSol,
  output logic outEol,
  output logic outBusy
);
  localparam int ADDR_W = $clog2(LINE_MAX);
  localparam int PH_W   = $clog2(PHASES);
  localparam int WORDS  = 2 * PHASES;
  localparam int TAPS   = 8;
  localparam int PROD_W = 17;
  localparam int SUM_W  = 20;
  localparam logic [31:0] IDENT_LO = 32'h4000_0000;

  logic [7:0]  lineMem [LINE_MAX];
  logic [31:0] stgTbl  [WORDS];
  logic [31:0] actTbl  [WORDS];

  logic [15:0] intPart;
  logic [PH_W-1:0] phase;
  logic signed [17:0] lastPos;
  logic [TAPS*PROD_W-1:0] prodFlat;
  logic signed [SUM_W-1:0] sum, rnd, shr;
  logic [7:0] pixOut;

  assign intPart = acc[31:16];
  assign phase   = acc[15:16-PH_W];
  assign lastPos = $signed(18'(lineLen)) - 18'sd1;

  always_ff @(posedge clk) begin
    if (strb.pixWr) lineMem[wrAddr] <= inPix;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) begin
        stgTbl[w] <= (w % 2 == 0) ? IDENT_LO : 32'd0;
        actTbl[w] <= (w % 2 == 0) ? IDENT_LO : 32'd0;
      end
    end else begin
      if (cfgWrEn) stgTbl[cfgAddr] <= cfgWrData;
      if (strb.tblSwap)
        for (int w = 0; w < WORDS; w++) actTbl[w] <= stgTbl[w];
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    localparam bit HI = (t >= 4);
    logic signed [17:0] pos;
    logic [ADDR_W-1:0] idx;
    logic signed [7:0] tapC;
    logic [7:0] pixSel;
    logic signed [PROD_W-1:0] prod;
    assign pos  = $signed({2'b00, intPart}) + $signed(18'(t)) - 18'sd3;
    assign idx  = (pos < 18'sd0) ? '0 :
                  (pos > lastPos) ? lastPos[ADDR_W-1:0] : pos[ADDR_W-1:0];
    assign pixSel = lineMem[idx];
    assign tapC = actTbl[{phase, HI}][8*(t%4) +: 8];
    assign prod = tapC * $signed({1'b0, pixSel});
    assign prodFlat[t*PROD_W +: PROD_W] = prod;
  end

  always_comb begin
    sum = '0;
    for (int t = 0; t < TAPS; t++)
      sum = sum + SUM_W'($signed(prodFlat[t*PROD_W +: PROD_W]));
    rnd = sum + 20'sd32;
    shr = rnd >>> 6;
    if (shr < 20'sd0)        pixOut = 8'd0;
    else if (shr > 20'sd255) pixOut = 8'd255;
    else                     pixOut = shr[7:0];
  end

  assign outBusy = outValid && !outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPix   <= '0;
      outSol   <= 1'b0;
      outEol   <= 1'b0;
    end else if (strb.emit) begin
      outValid <= 1'b1;
      outPix   <= pixOut;
      outSol   <= strb.firstOut;
      outEol   <= strb.lastOut;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable({outPix, outSol, outEol})));
  // R9
  emit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit |=> outValid);
endmodule

// File: rtl/hscale_top.sv
module hscale_top
  import hs_pkg::*;
#(
  parameter int LINE_MAX = 64,
  parameter int PHASES   = 32,
  parameter int OCNT_W   = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  output logic inReady,
  input  logic [7:0] inPix,
  input  logic inSol,
  input  logic inEol,
  input  logic [$clog2(LINE_MAX+1)-1:0] inWidth,
  input  logic [OCNT_W-1:0] outWidth,
  input  logic [31:0] stepIn,
  input  logic [15:0] phaseInit,
  input  logic cfgWrEn,
  input  logic [$clog2(2*PHASES)-1:0] cfgAddr,
  input  logic [31:0] cfgWrData,
  input  logic cfgCommit,
  output logic outValid,
  input  logic outReady,
  output logic [7:0] outPix,
  output logic outSol,
  output logic outEol
);
  hsStrobe_t strb;
  logic [$clog2(LINE_MAX)-1:0] wrAddr;
  logic [31:0] acc;
  logic [$clog2(LINE_MAX+1)-1:0] lineLen;
  logic outBusy;

  hs_ctrl #(.LINE_MAX(LINE_MAX), .OCNT_W(OCNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSol(inSol), .inEol(inEol),
    .inReady(inReady), .inWidth(inWidth), .outWidth(outWidth),
    .stepIn(stepIn), .phaseInit(phaseInit), .cfgCommit(cfgCommit),
    .outBusy(outBusy), .strb(strb), .wrAddr(wrAddr), .acc(acc),
    .lineLen(lineLen)
  );

  hs_datapath #(.LINE_MAX(LINE_MAX), .PHASES(PHASES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .inPix(inPix),
    .acc(acc), .lineLen(lineLen), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .outReady(outReady), .outValid(outValid),
    .outPix(outPix), .outSol(outSol), .outEol(outEol), .outBusy(outBusy)
  );
endmodule

// File: tb/sim_hscale_top.sv
module sim_hscale_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 0, inSol = 0, inEol = 0, cfgWrEn = 0, cfgCommit = 0, outReady = 0;
  logic [7:0] inPix = 0;
  logic [6:0] inWidth = 0;
  logic [11:0] outWidth = 0;
  logic [31:0] stepIn = 0, cfgWrData = 0;
  logic [15:0] phaseInit = 0;
  logic [5:0] cfgAddr = 0;
  logic inReady, outValid, outSol, outEol;
  logic [7:0] outPix;

  always #4 clk = ~clk;

  hscale_top u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inPix(inPix),
    .inSol(inSol), .inEol(inEol), .inWidth(inWidth), .outWidth(outWidth),
    .stepIn(stepIn), .phaseInit(phaseInit), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgCommit(cfgCommit), .outValid(outValid),
    .outReady(outReady), .outPix(outPix), .outSol(outSol), .outEol(outEol)
  );

  int total = 0, bad = 0, cycles = 0;
  int stgC [32][8];
  int actC [32][8];
  int linePix [64];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // rows: inW, outW, phaseInit, pattern, table, readyMode, gapMode, eolEarly
  localparam int NV = 10;
  localparam int VEC [NV][8] = '{
    '{16, 16, 0,      0, 0, 0, 0, 0},
    '{16, 32, 0,      0, 0, 1, 0, 0},
    '{32, 16, 0,      2, 0, 0, 1, 0},
    '{ 1,  5, 0,      0, 0, 0, 0, 0},
    '{12, 20, 0,      0, 0, 2, 1, 1},
    '{10, 23, 32768,  0, 1, 0, 0, 0},
    '{24, 40, 0,      2, 1, 2, 0, 0},
    '{64,  7, 63488,  0, 1, 1, 1, 0},
    '{18, 18, 0,      1, 2, 0, 0, 0},
    '{18, 30, 16384,  1, 2, 1, 1, 0}
  };

  function automatic int patPix(int pat, int i);
    if (pat == 0) return (i * 37 + 11) % 256;
    if (pat == 1) return ((i / 3) % 2 == 1) ? 255 : 0;
    return (i * 4) % 256;
  endfunction

  function automatic int expPix(int k, int len, longint step, int ph);
    longint a;
    int ip, p, s, pos;
    a = longint'(ph) + longint'(k) * step;
    ip = int'(a >> 16);
    p = int'((a >> 11) & 31);
    s = 0;
    for (int t = 0; t < 8; t++) begin
      pos = ip + t - 3;
      if (pos < 0) pos = 0;
      if (pos > len - 1) pos = len - 1;
      s += actC[p][t] * linePix[pos];
    end
    s = (s + 32) >>> 6;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic setTable(int kind);
    for (int p = 0; p < 32; p++)
      for (int t = 0; t < 8; t++) begin
        stgC[p][t] = 0;
        if (kind == 0 && t == 3) stgC[p][t] = 64;
        if (kind == 1 && t == 3) stgC[p][t] = 64 - 2 * p;
        if (kind == 1 && t == 4) stgC[p][t] = 2 * p;
        if (kind == 2 && t == 2) stgC[p][t] = -32;
        if (kind == 2 && t == 3) stgC[p][t] = 80;
        if (kind == 2 && t == 5) stgC[p][t] = 16;
      end
    for (int w = 0; w < 64; w++) begin
      logic [31:0] word;
      for (int b = 0; b < 4; b++) word[8*b +: 8] = 8'(stgC[w / 2][(w % 2) * 4 + b]);
      @(negedge clk);
      cfgWrEn = 1; cfgAddr = 6'(w); cfgWrData = word;
    end
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfgCommit = 1;
    @(negedge clk);
    cfgCommit = 0;
    @(negedge clk);
    actC = stgC;
  endtask

  task automatic runLine(int inW, int outW, int ph, int pat, int rdy, int gap,
                         int eolE, string req);
    longint step;
    int sent, got, cyc, e;
    bit fire;
    step = (longint'(inW) << 16) / outW;
    for (int i = 0; i < inW; i++) linePix[i] = patPix(pat, i);
    inWidth = eolE ? 7'd64 : 7'(inW);
    outWidth = 12'(outW);
    stepIn = 32'(step);
    phaseInit = 16'(ph);
    sent = 0; got = 0; cyc = 0;
    while (got < outW && cyc < 4000) begin
      @(negedge clk);
      if (sent < inW && !(gap != 0 && cyc % 4 == 1)) begin
        inValid = 1;
        inPix = 8'(linePix[sent]);
        inSol = (sent == 0);
        inEol = eolE != 0 && sent == inW - 1;
      end else begin
        inValid = 0; inSol = 0; inEol = 0;
      end
      if (rdy == 0) outReady = 1;
      else if (rdy == 1) outReady = (cyc % 3 != 0);
      else outReady = (cyc % 5 < 2);
      fire = inValid && inReady;
      if (outValid && outReady) begin
        e = expPix(got, inW, step, ph);
        check(outPix == 8'(e), {req, " pixel"}, outPix, e);
        check(outSol == (got == 0), "R3 sol", outSol, got == 0);
        check(outEol == (got == outW - 1), "R3 eol", outEol, got == outW - 1);
        got++;
      end
      if (fire) sent++;
      cyc++;
    end
    @(negedge clk);
    inValid = 0; inSol = 0; inEol = 0; outReady = 1;
    check(got == outW, "R3 count", got, outW);
    check(sent == inW, "R2 accepted", sent, inW);
    repeat (3) @(negedge clk);
    check(outValid == 0, "R3 no extra output", outValid, 0);
    check(inReady == 1, "R2 ready after line", inReady, 1);
  endtask

  initial begin
    for (int p = 0; p < 32; p++)
      for (int t = 0; t < 8; t++) begin
        stgC[p][t] = (t == 3) ? 64 : 0;
        actC[p][t] = stgC[p][t];
      end
    repeat (3) @(negedge clk);
    check(outValid == 0, "R1 outValid", outValid, 0);
    rstN = 1;
    @(negedge clk);
    check(inReady == 1, "R1 inReady", inReady, 1);

    begin
      int curTbl = 0;
      for (int v = 0; v < NV; v++) begin
        if (VEC[v][4] != curTbl) begin
          setTable(VEC[v][4]);
          commit();
          curTbl = VEC[v][4];
        end
        runLine(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][5],
                VEC[v][6], VEC[v][7], "R4 R5 R6 R7 R9 R10");
      end
    end

    // R8: staged table without commit keeps the sharpen filter
    setTable(1);
    runLine(18, 25, 0, 1, 0, 0, 0, "R8 uncommitted");
    commit();
    runLine(18, 25, 8192, 0, 1, 0, 0, "R8 committed");

    // R1: reset mid-line restores idle ports and pass-through table
    @(negedge clk);
    inWidth = 7'd20; outWidth = 12'd20; stepIn = 32'h10000; phaseInit = 0;
    for (int i = 0; i < 20; i++) begin
      inValid = 1; inSol = (i == 0); inPix = 8'(i * 3);
      @(negedge clk);
    end
    inValid = 0; inSol = 0; outReady = 0;
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    check(outValid == 0, "R1 outValid after reset", outValid, 0);
    check(inReady == 1, "R1 inReady after reset", inReady, 1);
    rstN = 1;
    for (int p = 0; p < 32; p++)
      for (int t = 0; t < 8; t++) actC[p][t] = (t == 3) ? 64 : 0;
    runLine(9, 13, 0, 2, 0, 0, 0, "R1 table");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule